// File: doc/BRIEF.md
# Pipeline Stage Control Word Carrier

This block is the control path of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). The fetched instruction word is captured into a fetch/decode holding register. There it is decoded once into a single control word. That word then rides along with its instruction through three further stage registers: decode-to-execute, execute-to-memory and memory-to-writeback. Each stage drives only the slice it needs, and no stage decodes the instruction again. The arithmetic datapath, the register file and the memories sit outside the block. They take the per-stage control outputs and the held instruction word from it.

Every instruction class that writes the register file does so in the fifth stage. A register-register or immediate ALU result therefore passes through the memory stage unused, and the single write port never sees two writers in the same cycle. A branch compares its operands and picks its target in execute. The instruction fetched straight after a branch always completes as a delay slot, so the block never squashes it. Each cycle the block takes one of three issue actions, named ADVANCE, HOLD and FLUSH. ADVANCE moves the pipeline forward normally. HOLD, taken on a stall request, freezes fetch and the holding register and sends a bubble into execute. FLUSH, taken on a flush request, fills both the holding register and the execute register with bubbles and has priority over HOLD.

Top module: `stage_ctl_pipe`

## Requirements
- R1: While reset is asserted and directly after it, every stage valid bit, `mem_write` and `wb_reg_write` read 0, and no stage writes state until a real instruction reaches it.
- R2: The opcode is bits [31:28] and the ALU sub-code is bits [2:0]. Opcode 0 is register-register: sub-code 0..4 gives ALU operation 0 add, 1 sub, 2 and, 3 or, 4 set-less-than; it selects the rd destination and writes the register. Opcode 1 is add-immediate with sign extension. Opcode 2 is or-immediate with zero extension. Opcode 3 is a load (sign extension, add, memory-to-register, register write). Opcode 4 is a store (sign extension, add, memory write). Opcode 5 is branch-if-equal (sign extension, register operand, sub, branch).
- R3: The execute fields (`ex_sign_ext`, `ex_alu_imm`, `ex_alu_op`, `ex_dst_rd`) of an instruction appear one clock after it is held in decode, that is two rising edges after the instruction is sampled on `instr`.
- R4: `mem_write` and `mem_branch` of an instruction appear one clock after its execute fields.
- R5: `wb_mem_to_reg` and `wb_reg_write` appear one clock after the memory fields. Every register-writing class, ALU or load, drives `wb_reg_write` only in this fifth stage.
- R6: An opcode of 6 to 15, or opcode 0 with sub-code 5 to 7, decodes to an all-zero control word, so it acts as a bubble.
- R7: On `stall` without `flush`, `fetch_en` is low, the decode holding register (`id_valid`, `id_instr`) keeps its value, and a bubble enters execute. Memory and writeback still advance.
- R8: A bubble clears valid, register write and memory write in the stage being filled. It keeps the other decoded fields of the instruction that was held in decode.
- R9: On `flush`, `fetch_en` is high, and the decode holding register and the execute register are both loaded with bubbles. `flush` wins over `stall`.
- R10: A branch squashes nothing: the instruction that follows it completes and writes back.
- R11: Each stage valid bit equals the valid bit of the stage before it one clock earlier. A stage that is not valid never drives a memory write or a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word fetched this cycle |
| stall | input | 1 | Request to hold fetch and decode |
| flush | input | 1 | Request to discard the two youngest instructions |
| fetch_en | output | 1 | Program counter may advance |
| id_valid | output | 1 | Decode holding register holds a real instruction |
| id_instr | output | 32 | Instruction held in decode, for register reads |
| ex_valid | output | 1 | Execute stage valid |
| ex_sign_ext | output | 1 | Immediate sign extension (0 = zero extension) |
| ex_alu_imm | output | 1 | ALU second operand is the immediate |
| ex_alu_op | output | 3 | ALU operation code |
| ex_dst_rd | output | 1 | Destination is the rd field (0 = rt field) |
| mem_valid | output | 1 | Memory stage valid |
| mem_write | output | 1 | Data memory write |
| mem_branch | output | 1 | Branch decision stage flag |
| wb_valid | output | 1 | Writeback stage valid |
| wb_mem_to_reg | output | 1 | Write data comes from memory |
| wb_reg_write | output | 1 | Register file write |

## Verification
A wrongly decoded or wrongly bubbled control word shows on the execute outputs exactly two edges after the instruction is sampled. It then reappears on the memory outputs one edge later and on the writeback outputs one edge after that. A stage register that drops or duplicates a word is therefore visible within four cycles. A hold or flush error shows at once on `fetch_en` and on the next edge on `id_valid`, `id_instr` and `ex_valid`. The bench sweeps every opcode and sub-code value, mixes stalls and flushes at random, and compares every stage output each cycle against an instruction-level model built from the requirements.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int OPC_W = 4;
    localparam int FN_W  = 3;

    localparam logic [OPC_W-1:0] OPC_RR    = 4'd0;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_ORI   = 4'd2;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd4;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 4'd5;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alu_op_e;

    localparam logic [FN_W-1:0] RR_FN_MAX = 3'd4;

    // full word produced in decode; execute slice first, then memory, then writeback
    typedef struct packed {
        logic    valid;
        logic    sign_ext;
        logic    alu_imm;
        alu_op_e alu_op;
        logic    dst_rd;
        logic    mem_wr;
        logic    branch;
        logic    mem_to_reg;
        logic    reg_wr;
    } ctl_word_t;

    typedef struct packed {
        logic valid;
        logic mem_wr;
        logic branch;
        logic mem_to_reg;
        logic reg_wr;
    } mem_word_t;

    typedef struct packed {
        logic valid;
        logic mem_to_reg;
        logic reg_wr;
    } wb_word_t;

    typedef enum logic [1:0] {
        ACT_ADVANCE = 2'd0,
        ACT_HOLD    = 2'd1,
        ACT_FLUSH   = 2'd2
    } issue_act_e;

    // a bubble drops the three state-changing bits and keeps the rest
    function automatic ctl_word_t bubble_ctl(input ctl_word_t w);
        ctl_word_t r;
        r        = w;
        r.valid  = 1'b0;
        r.mem_wr = 1'b0;
        r.reg_wr = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/scp_decode.sv
module scp_decode
    import scp_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output ctl_word_t        ctl
);

    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RR: begin
                if (funct <= RR_FN_MAX) begin
                    ctl.valid  = 1'b1;
                    ctl.alu_op = alu_op_e'(funct);
                    ctl.dst_rd = 1'b1;
                    ctl.reg_wr = 1'b1;
                end
            end
            OPC_ADDI: begin
                ctl.valid    = 1'b1;
                ctl.sign_ext = 1'b1;
                ctl.alu_imm  = 1'b1;
                ctl.alu_op   = ALU_ADD;
                ctl.reg_wr   = 1'b1;
            end
            OPC_ORI: begin
                ctl.valid   = 1'b1;
                ctl.alu_imm = 1'b1;
                ctl.alu_op  = ALU_OR;
                ctl.reg_wr  = 1'b1;
            end
            OPC_LOAD: begin
                ctl.valid      = 1'b1;
                ctl.sign_ext   = 1'b1;
                ctl.alu_imm    = 1'b1;
                ctl.alu_op     = ALU_ADD;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_wr     = 1'b1;
            end
            OPC_STORE: begin
                ctl.valid    = 1'b1;
                ctl.sign_ext = 1'b1;
                ctl.alu_imm  = 1'b1;
                ctl.alu_op   = ALU_ADD;
                ctl.mem_wr   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.valid    = 1'b1;
                ctl.sign_ext = 1'b1;
                ctl.alu_op   = ALU_SUB;
                ctl.branch   = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/scp_issue.sv
module scp_issue
    import scp_pkg::*;
(
    input  logic stall,
    input  logic flush,
    input  logic ifid_valid,
    output logic fetch_en,
    output logic ifid_load,
    output logic ifid_fill_valid,
    output logic idex_bubble
);

    issue_act_e act;

    always_comb begin
        if (flush)      act = ACT_FLUSH;
        else if (stall) act = ACT_HOLD;
        else            act = ACT_ADVANCE;
    end

    always_comb begin
        fetch_en        = 1'b1;
        ifid_load       = 1'b1;
        ifid_fill_valid = 1'b1;
        idex_bubble     = 1'b0;
        unique case (act)
            ACT_ADVANCE: begin
                idex_bubble = !ifid_valid;
            end
            ACT_HOLD: begin
                fetch_en    = 1'b0;
                ifid_load   = 1'b0;
                idex_bubble = 1'b1;
            end
            ACT_FLUSH: begin
                ifid_fill_valid = 1'b0;
                idex_bubble     = 1'b1;
            end
            default: begin
                idex_bubble = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/scp_stage_reg.sv
module scp_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

endmodule

// File: rtl/stage_ctl_pipe.sv
module stage_ctl_pipe
    import scp_pkg::*;
#(
    parameter int IW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] instr,
    input  logic          stall,
    input  logic          flush,
    output logic          fetch_en,
    output logic          id_valid,
    output logic [IW-1:0] id_instr,
    output logic          ex_valid,
    output logic          ex_sign_ext,
    output logic          ex_alu_imm,
    output logic [2:0]    ex_alu_op,
    output logic          ex_dst_rd,
    output logic          mem_valid,
    output logic          mem_write,
    output logic          mem_branch,
    output logic          wb_valid,
    output logic          wb_mem_to_reg,
    output logic          wb_reg_write
);

    localparam int IFID_W = IW + 1;
    localparam int CTL_W  = $bits(ctl_word_t);
    localparam int MEM_W  = $bits(mem_word_t);
    localparam int WB_W   = $bits(wb_word_t);

    logic              ifid_load;
    logic              ifid_fill_valid;
    logic              idex_bubble;
    logic [IFID_W-1:0] ifid_d;
    logic [IFID_W-1:0] ifid_q;
    ctl_word_t         dec_w;
    ctl_word_t         idex_d;
    ctl_word_t         idex_q;
    mem_word_t         exmem_d;
    mem_word_t         exmem_q;
    wb_word_t          memwb_d;
    wb_word_t          memwb_q;

    scp_issue u_issue (
        .stall           (stall),
        .flush           (flush),
        .ifid_valid      (ifid_q[IW]),
        .fetch_en        (fetch_en),
        .ifid_load       (ifid_load),
        .ifid_fill_valid (ifid_fill_valid),
        .idex_bubble     (idex_bubble)
    );

    assign ifid_d = {ifid_fill_valid, instr};

    scp_stage_reg #(.W(IFID_W)) u_ifid (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ifid_load),
        .d     (ifid_d),
        .q     (ifid_q)
    );

    scp_decode u_dec (
        .opcode (ifid_q[IW-1 -: OPC_W]),
        .funct  (ifid_q[FN_W-1:0]),
        .ctl    (dec_w)
    );

    assign idex_d = idex_bubble ? bubble_ctl(dec_w) : dec_w;

    scp_stage_reg #(.W(CTL_W)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (1'b1),
        .d     (idex_d),
        .q     (idex_q)
    );

    always_comb begin
        exmem_d.valid      = idex_q.valid;
        exmem_d.mem_wr     = idex_q.mem_wr;
        exmem_d.branch     = idex_q.branch;
        exmem_d.mem_to_reg = idex_q.mem_to_reg;
        exmem_d.reg_wr     = idex_q.reg_wr;
    end

    scp_stage_reg #(.W(MEM_W)) u_exmem (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (1'b1),
        .d     (exmem_d),
        .q     (exmem_q)
    );

    always_comb begin
        memwb_d.valid      = exmem_q.valid;
        memwb_d.mem_to_reg = exmem_q.mem_to_reg;
        memwb_d.reg_wr     = exmem_q.reg_wr;
    end

    scp_stage_reg #(.W(WB_W)) u_memwb (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (1'b1),
        .d     (memwb_d),
        .q     (memwb_q)
    );

    assign id_valid      = ifid_q[IW];
    assign id_instr      = ifid_q[IW-1:0];
    assign ex_valid      = idex_q.valid;
    assign ex_sign_ext   = idex_q.sign_ext;
    assign ex_alu_imm    = idex_q.alu_imm;
    assign ex_alu_op     = idex_q.alu_op;
    assign ex_dst_rd     = idex_q.dst_rd;
    assign mem_valid     = exmem_q.valid;
    assign mem_write     = exmem_q.mem_wr;
    assign mem_branch    = exmem_q.branch;
    assign wb_valid      = memwb_q.valid;
    assign wb_mem_to_reg = memwb_q.mem_to_reg;
    assign wb_reg_write  = memwb_q.reg_wr;

endmodule

// File: rtl/scp_chk.sv
module scp_chk
    import scp_pkg::*;
#(
    parameter int IW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          flush,
    input logic          fetch_en,
    input logic          id_valid,
    input logic [IW-1:0] id_instr,
    input ctl_word_t     ex_word,
    input mem_word_t     mem_word,
    input logic          wb_valid,
    input logic          wb_mem_to_reg,
    input logic          wb_reg_write
);

    p_hold_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |-> !fetch_en);

    p_hold_decode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> (id_valid == $past(id_valid)) && (id_instr == $past(id_instr)));

    p_hold_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush) |=> (!ex_word.valid && !ex_word.mem_wr && !ex_word.reg_wr));

    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!id_valid && !ex_word.valid));

    p_flush_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> fetch_en);

    p_mem_follows_ex_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {mem_word.valid, mem_word.mem_wr, mem_word.branch, mem_word.mem_to_reg, mem_word.reg_wr}
                 == $past({ex_word.valid, ex_word.mem_wr, ex_word.branch, ex_word.mem_to_reg, ex_word.reg_wr}));

    p_wb_follows_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> {wb_valid, wb_mem_to_reg, wb_reg_write}
                 == $past({mem_word.valid, mem_word.mem_to_reg, mem_word.reg_wr}));

    p_idle_mem_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_word.valid |-> !mem_word.mem_wr);

    p_idle_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> !wb_reg_write);

endmodule

bind stage_ctl_pipe scp_chk #(.IW(IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall         (stall),
    .flush         (flush),
    .fetch_en      (fetch_en),
    .id_valid      (id_valid),
    .id_instr      (id_instr),
    .ex_word       (idex_q),
    .mem_word      (exmem_q),
    .wb_valid      (wb_valid),
    .wb_mem_to_reg (wb_mem_to_reg),
    .wb_reg_write  (wb_reg_write)
);

// File: tb/stage_ctl_pipe_test.sv
module stage_ctl_pipe_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr;
    logic        stall;
    logic        flush;
    logic        fetch_en, id_valid;
    logic [31:0] id_instr;
    logic        ex_valid, ex_sign_ext, ex_alu_imm, ex_dst_rd;
    logic [2:0]  ex_alu_op;
    logic        mem_valid, mem_write, mem_branch;
    logic        wb_valid, wb_mem_to_reg, wb_reg_write;

    always #2 clk = ~clk;

    stage_ctl_pipe uut (
        .clk(clk), .rst_n(rst_n), .instr(instr), .stall(stall), .flush(flush),
        .fetch_en(fetch_en), .id_valid(id_valid), .id_instr(id_instr),
        .ex_valid(ex_valid), .ex_sign_ext(ex_sign_ext), .ex_alu_imm(ex_alu_imm),
        .ex_alu_op(ex_alu_op), .ex_dst_rd(ex_dst_rd),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_branch(mem_branch),
        .wb_valid(wb_valid), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_write(wb_reg_write)
    );

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    string phase = "";
    logic [31:0] lfsr = 32'h1bad_5eed;

    // instruction-level model; word order {valid,sx,imm,op[2:0],rd,mw,br,m2r,rw}
    logic [31:0] m_id_instr = '0;
    logic        m_id_v     = 1'b0;
    logic [10:0] m_ex       = '0;
    logic [4:0]  m_mem      = '0;
    logic [2:0]  m_wb       = '0;

    function automatic logic [10:0] ref_dec(input logic [31:0] w);
        logic [3:0] op = w[31:28];
        logic [2:0] fn = w[2:0];
        case (op)
            4'd0:    return (fn <= 3'd4) ? {3'b100, fn, 5'b10001} : 11'd0;
            4'd1:    return {3'b111, 3'd0, 5'b00001};
            4'd2:    return {3'b101, 3'd3, 5'b00001};
            4'd3:    return {3'b111, 3'd0, 5'b00011};
            4'd4:    return {3'b111, 3'd0, 5'b01000};
            4'd5:    return {3'b110, 3'd1, 5'b00100};
            default: return 11'd0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s [%s] act=%h exp=%h", tag, phase, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [2:0] fn);
        return {op, lfsr[24:0], fn};
    endfunction

    task automatic next_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [31:0] i, input logic s, input logic f);
        logic [10:0] nx;
        instr = i; stall = s; flush = f;
        #1;
        check("R7 R9 fetch_en", 64'(fetch_en), 64'(!s || f));
        @(posedge clk);
        m_wb  = {m_mem[4], m_mem[1], m_mem[0]};
        m_mem = {m_ex[10], m_ex[3], m_ex[2], m_ex[1], m_ex[0]};
        nx    = ref_dec(m_id_instr);
        if (f || s || !m_id_v) nx = nx & 11'b011_1111_0110;
        m_ex  = nx;
        if (f) begin
            m_id_v = 1'b0; m_id_instr = i;
        end else if (!s) begin
            m_id_v = 1'b1; m_id_instr = i;
        end
        @(negedge clk);
        check("R7 R9 decode hold", {31'd0, id_valid, id_instr}, {31'd0, m_id_v, m_id_instr});
        check("R2 R3 R6 R8 execute", 64'({ex_valid, ex_sign_ext, ex_alu_imm, ex_alu_op, ex_dst_rd}), 64'(m_ex[10:4]));
        check("R4 R11 memory", 64'({mem_valid, mem_write, mem_branch}), 64'({m_mem[4], m_mem[3], m_mem[2]}));
        check("R5 R11 writeback", 64'({wb_valid, wb_mem_to_reg, wb_reg_write}), 64'(m_wb));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; instr = '0; stall = 1'b0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        phase = "R1 reset";
        check("R1 reset state", 64'({id_valid, ex_valid, mem_valid, wb_valid, mem_write, wb_reg_write}), 64'd0);
        check("R1 reset fetch", 64'(fetch_en), 64'd1);
        rst_n = 1'b1;

        // R2 R6 sweep of every opcode and sub-code, plus R3 R4 R5 timing
        phase = "R2 R6 sweep";
        for (int op = 0; op < 16; op++) begin
            for (int fn = 0; fn < 8; fn++) begin
                step(mk(4'(op), 3'(fn)), 1'b0, 1'b0);
                next_lfsr();
            end
        end

        // R8 bubble keeps decoded fields of a held load
        phase = "R8 bubble fields";
        step(mk(4'd3, 3'd0), 1'b0, 1'b0);
        step(mk(4'd1, 3'd0), 1'b1, 1'b0);
        check("R8 bubble keeps fields", 64'({ex_valid, ex_sign_ext, ex_alu_imm, ex_alu_op}), 64'({1'b0, 1'b1, 1'b1, 3'd0}));
        step(mk(4'd1, 3'd0), 1'b0, 1'b0);
        check("R7 released load enters execute", 64'({ex_valid, ex_sign_ext, ex_alu_imm}), 64'(3'b111));

        // R10 delay slot after a branch
        phase = "R10 delay slot";
        step(mk(4'd5, 3'd0), 1'b0, 1'b0);
        step(mk(4'd1, 3'd0), 1'b0, 1'b0);
        step(32'hF000_0000, 1'b0, 1'b0);
        step(32'hF000_0000, 1'b0, 1'b0);
        check("R10 branch reaches writeback", 64'({wb_valid, wb_mem_to_reg, wb_reg_write}), 64'(3'b100));
        step(32'hF000_0000, 1'b0, 1'b0);
        check("R10 slot instruction writes", 64'({wb_valid, wb_mem_to_reg, wb_reg_write}), 64'(3'b101));

        // R7 random stalls
        phase = "R7 stalls";
        for (int k = 0; k < 300; k++) begin
            step(mk({1'b0, lfsr[7:5]}, lfsr[10:8]), lfsr[3] & lfsr[4], 1'b0);
            next_lfsr();
        end

        // R9 random flushes mixed with stalls
        phase = "R9 flush";
        for (int k = 0; k < 300; k++) begin
            step(mk({1'b0, lfsr[7:5]}, lfsr[10:8]), lfsr[3], lfsr[4] & lfsr[12]);
            next_lfsr();
        end

        // R1 R11 drain to empty pipeline
        phase = "R11 drain";
        for (int k = 0; k < 5; k++) step(32'hF000_0000, 1'b0, 1'b0);
        check("R11 drained", 64'({ex_valid, mem_valid, wb_valid, mem_write, wb_reg_write}), 64'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule